// File: doc/BRIEF.md
# Serial Output Freeze Controller

This block lets a host stop and restart individual clock outputs of a clock-distribution macro through a two-wire serial link. The host drives a data line and a free-running serial clock. The receiver sits idle while the data line is high. A low bit opens a frame, and the twelve bits that follow form an enable word. Each bit of that word owns one output clock. A one lets the clock through and a zero parks it at logic low.

The receiver loads the finished word into a register in the serial-clock domain. Each enable bit then crosses into the output-side clock domain through its own two-flop synchronizer. A per-output gate samples the enable on the falling edge of that output's ungated clock, so the gate opens and closes only while the clock is low. No output ever shows a shortened high pulse.

The zero-skew reference output and the feedback output are not routed through this block, so the serial link cannot stop them.

Top module: `out_freeze_ctrl`

## Requirements
- R1: While the receiver is idle, a high data line is ignored. A low data bit sampled on a rising serial-clock edge opens a frame.
- R2: A frame carries 12 data bits, one per rising serial-clock edge. The first bit after the start bit is enable bit 0, and the last is enable bit 11.
- R3: Enable bit i drives gated output i. Bits 0-3 serve bank A outputs 0-3, bits 4-7 serve bank B outputs 0-3, bits 8-10 serve bank C outputs 1-3, and bit 11 serves the sync-pulse output. An enabled output reproduces its ungated clock.
- R4: An enable bit of 0 freezes its output at logic 0 for as long as the bit stays 0.
- R5: The enables change only on the rising serial-clock edge that samples the 12th data bit, so a partly received frame has no effect. Each enable then passes through two output-domain flops before it reaches its gate.
- R6: Reset (rst_n low, sampled synchronously) discards any frame in progress and sets all 12 enables to 1.
- R7: No runt pulse appears. A gated output rises only together with a rising edge of its ungated clock, and falls only together with a falling edge of it.
- R8: A new start bit is accepted on the serial-clock edge right after the 12th data bit, so frames may be sent back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Free-running serial clock; data sampled on its rising edge |
| sdata | input | 1 | Serial data; high when idle, start bit 0, then 12 enable bits |
| clk | input | 1 | Output-domain clock for the enable synchronizers |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of every clock |
| clk_raw | input | 12 | Ungated output clocks |
| gclk | output | 12 | Gated output clocks |

## Verification
The new word lands on the rising serial-clock edge that samples the 12th data bit. After that edge, two output-domain clock edges pass before the enable reaches its gate. The gate then switches at the next falling edge of that output's own clock, which takes at most six output-domain cycles with the bench's clock set. The bench therefore waits 16 output-domain cycles after the last bit before it counts high samples over a window. For the partial-frame case, the bench checks while the frame is still being sent, at a point where the word cannot yet have changed.

// File: rtl/sfz_pkg.sv
// Shared types for the serial output freeze controller.
package sfz_pkg;
    // Receiver state: waiting for a start bit, or shifting data bits.
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_DATA = 1'b1
    } rx_state_e;
endpackage

// File: rtl/sfz_serial_rx.sv
// Frame receiver in the serial-clock domain.
// Behaviour: on a low start bit it shifts in N_BITS bits, first bit at index 0,
// and loads the enable word only on the last bit.
// Assumptions: sclk is free running; the data line idles high; rst_n is held
// low for at least one sclk rising edge.
module sfz_serial_rx
    import sfz_pkg::*;
#(
    parameter int N_BITS = 12
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              sdata,
    output logic [N_BITS-1:0] word_o,
    output rx_state_e         state_o,
    output logic              last_bit_o
);
    localparam int                CNT_W    = $clog2(N_BITS);
    localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(N_BITS - 1);

    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [N_BITS-2:0] shreg_q;
    logic [N_BITS-1:0] word_q;

    assign last_bit_o = (state_q == RX_DATA) && (cnt_q == LAST_IDX);
    assign word_o     = word_q;
    assign state_o    = state_q;

    // Frame sequencing, bit shifting and word load on the final bit.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            word_q  <= '1;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    if (!sdata) begin
                        state_q <= RX_DATA;
                        cnt_q   <= '0;
                    end
                end
                RX_DATA: begin
                    if (cnt_q == LAST_IDX) begin
                        word_q  <= {sdata, shreg_q};
                        state_q <= RX_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        shreg_q <= {sdata, shreg_q[N_BITS-2:1]};
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sfz_en_sync.sv
// Per-bit multi-flop synchronizer into the output clock domain.
// Behaviour: each bit is synchronized on its own, with no word coherence.
// Assumptions: the source word changes at most once per frame, which is rare
// compared with STAGES clk cycles.
module sfz_en_sync #(
    parameter int N_BITS = 12,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] din,
    output logic [N_BITS-1:0] dout
);
    logic [N_BITS-1:0] stg_q [STAGES];

    // Shift the enable word down the synchronizer chain; reset to all-enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
        end else begin
            stg_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sfz_clk_gate.sv
// Runt-free clock gate for one output.
// Behaviour: the enable is captured on the falling edge of the ungated clock,
// so it changes only while that clock is low; a frozen output sits at 0.
// Assumptions: en_i is stable around falling edges of clk_raw, which holds
// when clk_raw is derived from the synchronizer clock.
module sfz_clk_gate (
    input  logic clk_raw,
    input  logic rst_n,
    input  logic en_i,
    output logic gclk_o,
    output logic gate_en_o
);
    logic gate_q;

    // Capture the enable during the low phase of the ungated clock.
    always_ff @(negedge clk_raw) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= en_i;
    end

    assign gclk_o    = clk_raw & gate_q;
    assign gate_en_o = gate_q;
endmodule

// File: rtl/out_freeze_ctrl.sv
// Serial output freeze controller, top level.
// Behaviour: receives a start-bit framed enable word and gates N_OUT clocks.
// Assumptions: rst_n is held low long enough to cover several edges of sclk,
// clk and every clk_raw.
module out_freeze_ctrl
    import sfz_pkg::*;
#(
    parameter int N_OUT       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             sclk,
    input  logic             sdata,
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] clk_raw,
    output logic [N_OUT-1:0] gclk
);
    logic [N_OUT-1:0] word;
    logic [N_OUT-1:0] en_sync;
    logic [N_OUT-1:0] gate_en;
    rx_state_e        rx_state;
    logic             rx_last;

    sfz_serial_rx #(.N_BITS(N_OUT)) u_rx (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .sdata      (sdata),
        .word_o     (word),
        .state_o    (rx_state),
        .last_bit_o (rx_last)
    );

    sfz_en_sync #(.N_BITS(N_OUT), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (word),
        .dout  (en_sync)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_gate
        sfz_clk_gate u_gate (
            .clk_raw   (clk_raw[i]),
            .rst_n     (rst_n),
            .en_i      (en_sync[i]),
            .gclk_o    (gclk[i]),
            .gate_en_o (gate_en[i])
        );
    end
endmodule

// File: rtl/out_freeze_ctrl_chk.sv
// Assertion checker for out_freeze_ctrl, attached through bind.
// Behaviour: observes receiver state, enable word, synchronizer output and
// gated clocks.
// Assumptions: clk_raw edges coincide with clk rising edges.
module out_freeze_ctrl_chk
    import sfz_pkg::*;
#(
    parameter int N_OUT = 12
) (
    input logic             clk,
    input logic             sclk,
    input logic             rst_n,
    input logic             sdata,
    input logic [N_OUT-1:0] clk_raw,
    input logic [N_OUT-1:0] gclk,
    input logic [N_OUT-1:0] word,
    input logic [N_OUT-1:0] en_sync,
    input logic [N_OUT-1:0] gate_en,
    input rx_state_e        state,
    input logic             last_bit
);
    // R1
    idle_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (state == RX_IDLE && sdata) |=> (state == RX_IDLE));

    // R1
    start_open_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (state == RX_IDLE && !sdata) |=> (state == RX_DATA));

    // R5
    word_update_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (word != $past(word)) |-> $past(last_bit));

    // R5
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_sync == $past(word, 2));

    // R6
    reset_word_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(rst_n) |-> (word == '1 && state == RX_IDLE));

    // R8
    back_to_back_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (last_bit && !sdata) |=> (state == RX_IDLE));

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        // R7
        rise_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gclk[i]) |-> $rose(clk_raw[i]));

        // R7
        fall_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gclk[i]) |-> $fell(clk_raw[i]));

        // R7
        gate_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(clk_raw[i]) && clk_raw[i]) |-> $stable(gate_en[i]));
    end
endmodule

bind out_freeze_ctrl out_freeze_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
    .clk      (clk),
    .sclk     (sclk),
    .rst_n    (rst_n),
    .sdata    (sdata),
    .clk_raw  (clk_raw),
    .gclk     (gclk),
    .word     (word),
    .en_sync  (en_sync),
    .gate_en  (gate_en),
    .state    (rx_state),
    .last_bit (rx_last)
);

// File: tb/out_freeze_ctrl_tb.sv
`timescale 1ns/1ps
module out_freeze_ctrl_tb;
    localparam int N = 12;

    logic         clk = 1'b0;
    logic         sclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sdata = 1'b1;
    logic [N-1:0] clk_raw = '0;
    logic [N-1:0] gclk;
    int           rcnt [N];
    int           n_checks = 0;
    int           n_fail = 0;
    int           runt_events = 0;
    bit           done = 1'b0;
    logic [N-1:0] prev_raw = '0;
    logic [N-1:0] prev_g = '0;

    out_freeze_ctrl #(.N_OUT(N)) u_dut (
        .sclk    (sclk),
        .sdata   (sdata),
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_raw (clk_raw),
        .gclk    (gclk)
    );

    always #2.5 clk = ~clk;
    initial begin
        #3;
        forever #10 sclk = ~sclk;
    end

    // Ungated clocks: output i toggles every (i%3)+1 core cycles.
    initial for (int i = 0; i < N; i++) rcnt[i] = 0;
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rcnt[i] == (i % 3)) begin
                rcnt[i]    <= 0;
                clk_raw[i] <= ~clk_raw[i];
            end else begin
                rcnt[i] <= rcnt[i] + 1;
            end
        end
    end

    // R7 monitor: gated edges must coincide with ungated edges of the same direction.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (gclk[i] && !prev_g[i] && !(clk_raw[i] && !prev_raw[i])) runt_events++;
                if (!gclk[i] && prev_g[i] && !(!clk_raw[i] && prev_raw[i])) runt_events++;
            end
        end
        prev_raw = clk_raw;
        prev_g   = gclk;
    end

    task automatic check_val(input int act, input int exp, input string tag, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Count high samples of each gated and ungated output over a window.
    task automatic check_outputs(input logic [N-1:0] exp, input string tag, input int win);
        int hg [N];
        int hr [N];
        for (int i = 0; i < N; i++) begin
            hg[i] = 0;
            hr[i] = 0;
        end
        repeat (win) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                hg[i] += int'(gclk[i]);
                hr[i] += int'(clk_raw[i]);
            end
        end
        for (int i = 0; i < N; i++)
            check_val(hg[i], exp[i] ? hr[i] : 0, tag, $sformatf("output %0d high samples", i));
    endtask

    task automatic settle();
        repeat (16) @(negedge clk);
    endtask

    task automatic send_head(input logic [N-1:0] w, input int nbits);
        @(negedge sclk) sdata = 1'b0;
        for (int b = 0; b < nbits; b++) @(negedge sclk) sdata = w[b];
    endtask

    task automatic send_frame(input logic [N-1:0] w, input bit idle_after);
        send_head(w, N);
        if (idle_after) @(negedge sclk) sdata = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge sclk);
        sdata = 1'b1;
        rst_n = 1'b0;
        repeat (10) @(negedge sclk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        settle();
        check_outputs('1, "R6", 24);
    endtask

    task automatic t_idle();
        sdata = 1'b1;
        repeat (30) @(negedge sclk);
        check_outputs('1, "R1", 24);
    endtask

    task automatic t_first_bit();
        send_frame(12'h001, 1'b1);
        settle();
        check_outputs(12'h001, "R2", 24);
    endtask

    task automatic t_freeze_all();
        send_frame(12'h000, 1'b1);
        settle();
        check_outputs(12'h000, "R4", 24);
    endtask

    task automatic t_map();
        send_frame(12'hA5C, 1'b1);
        settle();
        check_outputs(12'hA5C, "R3", 24);
    endtask

    task automatic t_partial();
        fork
            send_frame(12'h3F0, 1'b1);
            begin
                repeat (7) @(posedge sclk);
                check_outputs(12'hA5C, "R5", 8);
            end
        join
        settle();
        check_outputs(12'h3F0, "R5", 24);
    endtask

    task automatic t_back_to_back();
        send_frame(12'h0F0, 1'b0);
        send_frame(12'hF0F, 1'b1);
        settle();
        check_outputs(12'hF0F, "R8", 24);
    endtask

    task automatic t_reset_mid();
        send_head(12'h000, 5);
        do_reset();
        settle();
        check_outputs('1, "R6", 24);
        send_frame(12'h800, 1'b1);
        settle();
        check_outputs(12'h800, "R3", 24);
    endtask

    task automatic t_runt();
        check_val(runt_events, 0, "R7", "runt edge events");
    endtask

    initial begin
        t_reset();
        t_idle();
        t_first_bit();
        t_freeze_all();
        t_map();
        t_partial();
        t_back_to_back();
        t_reset_mid();
        t_runt();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule